// File: doc/BRIEF.md
# Flash thermometer-to-binary encoder

This block is the digital back end of a parallel (flash) converter. It takes the 63 one-bit decisions of a comparator bank, which normally form a thermometer code (a run of ones from the lowest comparator up to the input level, then zeros). It turns that run into a one-hot word of 64 lines that marks the single boundary between the high and the low comparators. An OR-plane lookup with one fixed code per line turns that word into a 6-bit binary result, and an edge-triggered register captures it.

Real comparator banks sometimes show bubbles: isolated wrong decisions above or below the true level. The one-hot stage always picks the lowest boundary, so one row is active for any input pattern. A parameter can add a register that captures the comparator vector before encoding. This costs one more cycle of latency and shortens the path between edges. Two enable inputs control the output: the per-bit output-enable for the pad drivers is active only when both are asserted.

Top module: `flash_therm_enc`

## Requirements
- R1: When no comparator is high (all-zero input), the converted code is 0.
- R2: When comparators 1 to k are high and the rest are low, the code is k, for every k from 1 to 62. Input bit i of `therm` carries comparator i+1.
- R3: When all 63 comparators are high, the code is 63.
- R4: For a non-monotonic input, the code equals the number of consecutive ones counted upward from bit 0. Every bit above the first zero is ignored.
- R5: For any input, exactly one of the 64 one-hot lines is active.
- R6: With PIPE_IN = 0, a vector present on `therm` before a rising edge appears on `code` after that edge. With PIPE_IN = 1, it appears after the following rising edge.
- R7: Distinct vectors applied on consecutive cycles each produce their own result on consecutive cycles.
- R8: `codeOe` is all ones after a rising edge at which `enA` and `enB` are both high and `rst` is low. After any other edge it is all zeros.
- R9: The code register keeps converting while the output is disabled, so the current result is present as soon as the output is enabled.
- R10: A rising edge with `rst` high clears `code` (and the optional input stage) to 0 and `codeOe` to all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous reset, active high |
| therm | input | NUM_COMP (63) | Comparator decisions, bit i = comparator i+1 |
| enA | input | 1 | First output enable, active high |
| enB | input | 1 | Second output enable, active high |
| code | output | CODE_W (6) | Registered binary result |
| codeOe | output | CODE_W (6) | Per-bit output-enable for the tri-state pad drivers |

## Verification
The encoder is driven with the all-zero and all-ones vectors and then with a full ramp of clean thermometer codes. These separate a correct row-to-code table from one with a wrong or shifted row. Bubble patterns follow: alternating bits, a lone high at the top, a hole just above a run, and random bits above a run with a forced zero. They show whether the lowest boundary really wins, or whether a higher run or an upper bit leaks into the result. Two copies, one with and one without the input stage, receive the same stream back to back. This checks the latency of each and a fresh result every cycle. Separate steps toggle each enable alone and convert while the output is disabled.

// File: rtl/flash_enc_pkg.sv
package flash_enc_pkg;
  // Strobes from the control half to the datapath
  typedef struct packed {
    logic clear;   // synchronous clear of every register
    logic drive;   // both enables asserted, outputs should drive
  } encStrobes_t;
endpackage

// File: rtl/flash_onehot.sv
module flash_onehot #(
  parameter int NUM_COMP = 63,
  localparam int ROWS = NUM_COMP + 1
) (
  input  logic [NUM_COMP-1:0] therm,
  output logic [ROWS-1:0]     rowVec
);
  // Extended vector: a virtual high below comparator 1, a virtual low above the top
  logic [NUM_COMP+1:0] ext;
  logic [ROWS-1:0]     edgeVec;
  logic [ROWS-1:0]     seen;

  assign ext     = {1'b0, therm, 1'b1};
  assign seen[0] = 1'b0;

  for (genvar k = 0; k < ROWS; k++) begin : g_row
    // A boundary at k: level k reads high and level k+1 reads low
    assign edgeVec[k] = ext[k] & ~ext[k+1];
    // Only the lowest boundary survives
    assign rowVec[k]  = edgeVec[k] & ~seen[k];
    if (k < ROWS - 1) begin : g_chain
      assign seen[k+1] = seen[k] | edgeVec[k];
    end
  end
endmodule

// File: rtl/flash_enc_ctrl.sv
module flash_enc_ctrl
  import flash_enc_pkg::*;
(
  input  logic        rst,
  input  logic        enA,
  input  logic        enB,
  output encStrobes_t strobes
);
  always_comb begin
    strobes.clear = rst;
    strobes.drive = enA & enB & ~rst;
  end
endmodule

// File: rtl/flash_enc_datapath.sv
module flash_enc_datapath
  import flash_enc_pkg::*;
#(
  parameter int NUM_COMP = 63,
  parameter int CODE_W   = $clog2(NUM_COMP + 1),
  parameter bit PIPE_IN  = 1'b0
) (
  input  logic                clk,
  input  encStrobes_t         strobes,
  input  logic [NUM_COMP-1:0] thermIn,
  output logic [CODE_W-1:0]   codeQ,
  output logic [CODE_W-1:0]   oeQ
);
  localparam int ROWS = NUM_COMP + 1;

  logic [NUM_COMP-1:0] stageVec;
  logic [ROWS-1:0]     rowVec;
  logic [CODE_W-1:0]   codeNext;

  // Optional capture of the comparator vector ahead of the encoder
  if (PIPE_IN) begin : g_stage
    always_ff @(posedge clk) begin
      if (strobes.clear) stageVec <= '0;
      else               stageVec <= thermIn;
    end
  end else begin : g_direct
    assign stageVec = thermIn;
  end

  flash_onehot #(.NUM_COMP(NUM_COMP)) i_onehot (
    .therm  (stageVec),
    .rowVec (rowVec)
  );

  // OR-plane lookup: row k contributes the fixed code k
  always_comb begin
    codeNext = '0;
    for (int k = 0; k < ROWS; k++) begin
      if (rowVec[k]) codeNext = codeNext | CODE_W'(k);
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.clear) begin
      codeQ <= '0;
      oeQ   <= '0;
    end else begin
      codeQ <= codeNext;
      oeQ   <= {CODE_W{strobes.drive}};
    end
  end

  AST_ONE_ROW: assert property (@(posedge clk) disable iff (strobes.clear)
    $countones(rowVec) == 1); // R5
  AST_ZERO_IN: assert property (@(posedge clk) disable iff (strobes.clear)
    (stageVec == '0) |=> (codeQ == '0)); // R1
  AST_FULL_IN: assert property (@(posedge clk) disable iff (strobes.clear)
    (&stageVec) |=> (codeQ == CODE_W'(NUM_COMP))); // R3
  AST_OE_ON: assert property (@(posedge clk) disable iff (strobes.clear)
    strobes.drive |=> (&oeQ)); // R8
  AST_OE_OFF: assert property (@(posedge clk) disable iff (strobes.clear)
    !strobes.drive |=> (oeQ == '0)); // R8
endmodule

// File: rtl/flash_therm_enc.sv
module flash_therm_enc
  import flash_enc_pkg::*;
#(
  parameter int NUM_COMP = 63,
  parameter int CODE_W   = $clog2(NUM_COMP + 1),
  parameter bit PIPE_IN  = 1'b0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_COMP-1:0] therm,
  input  logic                enA,
  input  logic                enB,
  output logic [CODE_W-1:0]   code,
  output logic [CODE_W-1:0]   codeOe
);
  encStrobes_t strobes;

  flash_enc_ctrl i_ctrl (
    .rst     (rst),
    .enA     (enA),
    .enB     (enB),
    .strobes (strobes)
  );

  flash_enc_datapath #(
    .NUM_COMP (NUM_COMP),
    .CODE_W   (CODE_W),
    .PIPE_IN  (PIPE_IN)
  ) i_dp (
    .clk     (clk),
    .strobes (strobes),
    .thermIn (therm),
    .codeQ   (code),
    .oeQ     (codeOe)
  );
endmodule

// File: tb/test_flash_therm_enc.sv
module test_flash_therm_enc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [62:0] therm = '1;
  logic        enA = 1'b1;
  logic        enB = 1'b1;
  logic [5:0]  codeF, oeF, codeP, oeP;

  int checks = 0;
  int fails  = 0;

  logic [5:0] expQ[$];
  string      tagQ[$];

  always #5 clk = ~clk;

  flash_therm_enc #(.NUM_COMP(63), .PIPE_IN(1'b0)) i_flash_therm_enc (
    .clk(clk), .rst(rst), .therm(therm), .enA(enA), .enB(enB),
    .code(codeF), .codeOe(oeF));

  flash_therm_enc #(.NUM_COMP(63), .PIPE_IN(1'b1)) i_flash_therm_enc_piped (
    .clk(clk), .rst(rst), .therm(therm), .enA(enA), .enB(enB),
    .code(codeP), .codeOe(oeP));

  // Reference: length of the run of ones from bit 0
  function automatic logic [5:0] refCode(input logic [62:0] v);
    int n = 0;
    for (int i = 0; i < 63; i++) begin
      if (!v[i]) break;
      n++;
    end
    return 6'(n);
  endfunction

  task automatic checkVal(input string tag, input string what,
                          input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Driver: apply a vector and queue its expected result
  task automatic send(input logic [62:0] v, input string tag);
    @(negedge clk);
    therm = v;
    expQ.push_back(refCode(v));
    tagQ.push_back(tag);
  endtask

  task automatic flushStream();
    send('0, "R1");
    @(negedge clk);
    expQ.delete();
    tagQ.delete();
  endtask

  // Monitor: fast copy answers after one edge, piped copy after two (R6)
  initial begin
    forever begin
      @(posedge clk);
      #3;
      if (expQ.size() >= 1)
        checkVal(tagQ[expQ.size()-1], "fast code", codeF, expQ[expQ.size()-1]);
      if (expQ.size() >= 2) begin
        logic [5:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checkVal({t, " R6"}, "piped code", codeP, e);
      end
    end
  end

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [62:0] v;
    // R10: reset with all comparators high and both enables asserted
    repeat (2) @(negedge clk);
    checkVal("R10", "fast code in reset", codeF, 6'd0);
    checkVal("R10", "piped code in reset", codeP, 6'd0);
    checkVal("R10", "fast oe in reset", oeF, 6'd0);
    checkVal("R10", "piped oe in reset", oeP, 6'd0);
    rst = 1'b0;
    @(negedge clk);
    checkVal("R8", "fast oe enabled", oeF, 6'h3f);
    checkVal("R8", "piped oe enabled", oeP, 6'h3f);

    // R1, R3, then the clean ramp back to back (R2, R7)
    send('0, "R1");
    send('1, "R3");
    send('0, "R1 R7");
    for (int k = 1; k < 63; k++) send((63'(1) << k) - 63'(1), "R2 R7");
    send('1, "R3 R7");

    // R4: bubble patterns
    send({32{2'b01}} [62:0], "R4 alternating low");
    send({32{2'b10}} [62:0], "R4 alternating high");
    send(63'(1) << 62, "R4 lone top");
    send(63'b1011, "R4 hole");
    send(63'b1110_1111, "R4 hole mid");
    send(~(63'(1) << 62), "R4 top off");
    for (int k = 0; k < 20; k++) begin
      v = 63'({$urandom(), $urandom()});
      v[(k * 3) % 63] = 1'b0;
      v = v | ((63'(1) << ((k * 3) % 63)) - 63'(1));
      send(v, "R4 random");
    end
    flushStream();

    // R8: each enable alone, then neither, then both
    enA = 1'b0;
    @(negedge clk);
    checkVal("R8", "oe with enA low", oeF, 6'd0);
    checkVal("R8", "piped oe with enA low", oeP, 6'd0);
    enA = 1'b1; enB = 1'b0;
    @(negedge clk);
    checkVal("R8", "oe with enB low", oeF, 6'd0);
    enA = 1'b0;
    @(negedge clk);
    checkVal("R8", "oe with both low", oeF, 6'd0);

    // R9: conversion continues while disabled
    therm = (63'(1) << 17) - 63'(1);
    repeat (2) @(negedge clk);
    checkVal("R9", "fast code while disabled", codeF, 6'd17);
    checkVal("R9", "piped code while disabled", codeP, 6'd17);
    checkVal("R9", "oe while disabled", oeP, 6'd0);
    enA = 1'b1; enB = 1'b1;
    @(negedge clk);
    checkVal("R8", "oe re-enabled", oeF, 6'h3f);
    checkVal("R9", "code on enable", codeF, 6'd17);

    // R10: mid-run reset clears code and oe
    therm = '1;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    checkVal("R10", "fast code after reset", codeF, 6'd0);
    checkVal("R10", "piped code after reset", codeP, 6'd0);
    checkVal("R10", "oe after reset", oeF, 6'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    checkVal("R3", "piped full after reset", codeP, 6'd63);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule